// File: doc/BRIEF.md
# Overflow-and-Match PWM Timer

This block is an up-counting timer that shapes a pulse-width-modulated output from two counter events. The counter rises from a programmable reload value to its all-ones ceiling. On the counting step after the ceiling it wraps and picks up the reload value again. The wrap drives the output to its active level. The counting step on which the counter leaves the compare value drives the output back to its inactive level. So the reload value's distance below the ceiling sets the period, and the compare value's position inside that span sets the high time.

Counting steps come from an enable pulse input, `fclk_en`. An optional power-of-two divider can thin those pulses first. Software-side logic programs the reload, compare and counter values and the control word through a simple one-cycle write port. Reload, compare and counter writes take effect only while the timer is stopped. A write to one of them while running is dropped and reported on a one-cycle error pulse. Starting the timer preloads the counter to one below the ceiling, so the first active edge comes on the second counting step. A control bit can instead keep the counter value that was written beforehand.

Top module: `pwm_toggle_timer`

## Requirements
- R1: On every counting step the counter advances by one. On a counting step taken at the all-ones value, it reloads the reload register instead.
- R2: With reload value L and compare value M (L <= M < all-ones), the output goes active on each wrap step. It stays active for M-L+1 steps and inactive for all-ones minus M steps, so one period is all-ones minus L plus 1 steps.
- R3: A control write (select 3) with bit 0 set while stopped starts the timer and loads the counter with all-ones minus 1, so the first wrap happens on the second counting step. If bit 2 is also set, the counter keeps the value last written through select 2.
- R4: Control bit 1 inverts the output. While stopped, `pwm_out` equals that bit, and while running it equals the active flag XOR that bit.
- R5: A control write with bit 0 clear stops the timer. From the next cycle `pwm_out` is at its inactive level, and the counter does not advance while stopped, whatever `fclk_en` does.
- R6: While running, writes to select 0 (reload), 1 (compare) or 2 (counter) are ignored, and `wr_err` is high for exactly the one cycle after such a write. A control write while running changes only the run bit and raises no error.
- R7: Control bit 3 enables the divider and bits [4 +: PRE_W] hold N. When enabled, one counting step occurs per 2^(N+1) `fclk_en` pulses, the first one on the 2^(N+1)-th pulse after the start. When disabled, every `fclk_en` pulse while running is a counting step.
- R8: After reset the timer is stopped, every register is zero, `pwm_out` is 0 and `wr_err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fclk_en | input | 1 | Counting-step enable pulse from the clock source |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 0 reload, 1 compare, 2 counter, 3 control |
| wr_data | input | CNT_W (32) | Write data |
| pwm_out | output | 1 | PWM output line |
| wr_err | output | 1 | One-cycle pulse after a dropped write |

## Verification
Assertions watch every cycle for the counter stepping by one or reloading at the ceiling, the output going active on each wrap, and the preload on start. They also check that the counter holds while stopped, that a reload write while running leaves the register unchanged, that an error pulse only follows a running cycle, and that the divider wraps on each divided step. The phase lengths (M-L+1 and all-ones minus M), the delay to the first edge after a start, inverted polarity, the divided step rate under gapped enable pulses, and the unchanged waveform after a rejected write mid-run depend on whole sequences of steps. Only the bench's scenarios can show those, by comparing every cycle of output against the period formula.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
   typedef enum logic [1:0] {
      SEL_RELOAD  = 2'd0,
      SEL_COMPARE = 2'd1,
      SEL_COUNTER = 2'd2,
      SEL_CONTROL = 2'd3
   } ptt_sel_e;

   // control word bit positions
   localparam int CB_RUN   = 0;
   localparam int CB_INV   = 1;
   localparam int CB_KEEP  = 2;
   localparam int CB_DIVEN = 3;
   localparam int CB_RATIO = 4;
endpackage

// File: rtl/ptt_regs.sv
module ptt_regs
   import ptt_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int PRE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] reload_q,
   output logic [CNT_W-1:0] compare_q,
   output logic             cnt_wr,
   output logic             start_pre,
   output logic             running,
   output logic             inv_q,
   output logic             diven_q,
   output logic [PRE_W-1:0] ratio_q,
   output logic             wr_err
);
   logic cfg_ok;
   logic is_ctl;

   assign cfg_ok    = wr_en && !running;
   assign is_ctl    = (wr_sel == SEL_CONTROL);
   assign cnt_wr    = cfg_ok && (wr_sel == SEL_COUNTER);
   assign start_pre = cfg_ok && is_ctl && wr_data[CB_RUN] && !wr_data[CB_KEEP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q  <= '0;
         compare_q <= '0;
         running   <= 1'b0;
         inv_q     <= 1'b0;
         diven_q   <= 1'b0;
         ratio_q   <= '0;
         wr_err    <= 1'b0;
      end else begin
         wr_err <= wr_en && running && !is_ctl;
         if (cfg_ok && wr_sel == SEL_RELOAD)  reload_q  <= wr_data;
         if (cfg_ok && wr_sel == SEL_COMPARE) compare_q <= wr_data;
         if (wr_en && is_ctl) begin
            running <= wr_data[CB_RUN];
            if (!running) begin
               inv_q   <= wr_data[CB_INV];
               diven_q <= wr_data[CB_DIVEN];
               ratio_q <= wr_data[CB_RATIO +: PRE_W];
            end
         end
      end
   end

   // R6: a reload write while running leaves the register untouched
   assert_ignore_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && running && wr_sel == SEL_RELOAD) |=> $stable(reload_q));
   // R6: an error pulse only follows a cycle in which the timer ran
   assert_err_when_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(running));
   // R6: writes while stopped never raise the error
   assert_no_err_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !running) |=> !wr_err);
endmodule

// File: rtl/ptt_prescale.sv
module ptt_prescale #(
   parameter int PRE_W        = 3,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             fclk_en,
   input  logic             diven,
   input  logic [PRE_W-1:0] ratio,
   output logic             tick
);
   localparam int DIV_W = 1 << PRE_W;

   generate
      if (HAS_PRESCALE) begin : g_div
         logic [DIV_W-1:0] divcnt;
         logic [DIV_W-1:0] lim;
         logic             at_lim;

         always_comb lim = ~({DIV_W{1'b1}} << (int'(ratio) + 1));
         assign at_lim = (divcnt == lim);
         assign tick   = run && fclk_en && (!diven || at_lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       divcnt <= '0;
            else if (!run)    divcnt <= '0;
            else if (fclk_en) divcnt <= at_lim ? '0 : divcnt + 1'b1;
         end

         // R7: a divided step restarts the divider
         assert_div_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (run && diven && tick) |=> (divcnt == '0));
         // R7: the divider is idle while the timer is stopped
         assert_div_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> (divcnt == '0));
      end else begin : g_nodiv
         logic unused_cfg;
         assign unused_cfg = diven ^ (^ratio) ^ clk ^ rst_n;
         assign tick = run && fclk_en;
      end
   endgenerate
endmodule

// File: rtl/ptt_core.sv
module ptt_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             start_pre,
   input  logic [CNT_W-1:0] reload_q,
   input  logic [CNT_W-1:0] compare_q,
   input  logic             inv_q,
   output logic             pwm_out
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;
   localparam logic [CNT_W-1:0] CNT_PRE = CNT_TOP - 1'b1;

   logic [CNT_W-1:0] cnt;
   logic             active;
   logic             wrap;
   logic             hit;

   assign wrap = tick && (cnt == CNT_TOP);
   assign hit  = tick && (cnt == compare_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (cnt_wr)    cnt <= cnt_wdata;
      else if (start_pre) cnt <= CNT_PRE;
      else if (tick)      cnt <= wrap ? reload_q : cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        active <= 1'b0;
      else if (!running) active <= 1'b0;
      else if (wrap)     active <= 1'b1;
      else if (hit)      active <= 1'b0;
   end

   assign pwm_out = (running && active) ^ inv_q;

   // R1: wrap at the ceiling picks up the reload value
   assert_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == CNT_TOP) |=> (cnt == $past(reload_q)));
   // R1: ordinary counting steps advance by one
   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt != CNT_TOP) |=> (cnt == $past(cnt) + 1'b1));
   // R2: output goes active on each wrap
   assert_active_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick && cnt == CNT_TOP) |=> active);
   // R3: start preloads one below the ceiling
   assert_preload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_pre |=> (cnt == CNT_PRE));
   // R5: counter holds while stopped
   assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !cnt_wr && !start_pre) |=> $stable(cnt));
endmodule

// File: rtl/pwm_toggle_timer.sv
module pwm_toggle_timer #(
   parameter int CNT_W        = 32,
   parameter int PRE_W        = 3,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fclk_en,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out,
   output logic             wr_err
);
   generate
      if (CNT_W < ptt_pkg::CB_RATIO + PRE_W)
         $error("CNT_W too narrow to hold the control word");
      if (PRE_W < 1 || PRE_W > 4)
         $error("PRE_W must lie between 1 and 4");
   endgenerate

   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] compare_q;
   logic             cnt_wr;
   logic             start_pre;
   logic             running;
   logic             inv_q;
   logic             diven_q;
   logic [PRE_W-1:0] ratio_q;
   logic             tick;

   ptt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .reload_q  (reload_q),
      .compare_q (compare_q),
      .cnt_wr    (cnt_wr),
      .start_pre (start_pre),
      .running   (running),
      .inv_q     (inv_q),
      .diven_q   (diven_q),
      .ratio_q   (ratio_q),
      .wr_err    (wr_err)
   );

   ptt_prescale #(.PRE_W(PRE_W), .HAS_PRESCALE(HAS_PRESCALE)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (running),
      .fclk_en (fclk_en),
      .diven   (diven_q),
      .ratio   (ratio_q),
      .tick    (tick)
   );

   ptt_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .running   (running),
      .tick      (tick),
      .cnt_wr    (cnt_wr),
      .cnt_wdata (wr_data),
      .start_pre (start_pre),
      .reload_q  (reload_q),
      .compare_q (compare_q),
      .inv_q     (inv_q),
      .pwm_out   (pwm_out)
   );

   // R4: stopped output sits at the polarity level
   assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3 && !wr_data[0]) |=> (pwm_out == inv_q));
endmodule

// File: tb/tb_pwm_toggle_timer.sv
`timescale 1ns/1ps
module tb_pwm_toggle_timer;
   localparam longint TOP = 64'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fclk_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic        pwm_out;
   logic        wr_err;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pwm_toggle_timer dut (
      .clk(clk), .rst_n(rst_n), .fclk_en(fclk_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out), .wr_err(wr_err)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // caller is at a negedge; returns at the next negedge
   task automatic do_wr(input logic [1:0] s, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic setup(input longint ld, input longint mt);
      do_wr(2'd3, 32'd0);
      do_wr(2'd0, ld[31:0]);
      do_wr(2'd1, mt[31:0]);
   endtask

   // Checks pwm_out and wr_err every cycle after a start write.
   // F: step index of the first wrap, P: period, A: active steps, D: steps divider
   task automatic run_trace(input int cycles, input longint F, input longint P,
                            input longint A, input int D, input bit inv, input int gap,
                            input int wr_at, input int ctl_at, input string req);
      longint n = 0;
      for (int i = 0; i < cycles; i++) begin
         longint t = n / D;
         bit act = (t >= F) && (((t - F) % P) < A);
         bit ee  = (wr_at >= 0) && (i == wr_at + 1);
         chk(pwm_out == (act ^ inv), req, longint'(pwm_out), longint'(act ^ inv));
         chk(wr_err == ee, "R6", longint'(wr_err), longint'(ee));
         fclk_en = (gap == 0) ? 1'b1 : ((i % 3) != 1);
         wr_en = 1'b0;
         if (i == wr_at) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'd0; end
         if (i == ctl_at) begin wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'h0000_000B; end
         if (fclk_en) n++;
         @(negedge clk);
      end
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      chk(pwm_out == 1'b0, "R8", longint'(pwm_out), 0);
      chk(wr_err == 1'b0, "R8", longint'(wr_err), 0);
      fclk_en = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(pwm_out == 1'b0, "R5", longint'(pwm_out), 0);
      end
   endtask

   task automatic t_basic();   // R1 R2 R3
      setup(TOP - 9, TOP - 6);
      fclk_en = 1'b1;
      do_wr(2'd3, 32'h1);
      run_trace(45, 2, 10, 4, 1, 1'b0, 0, -1, -1, "R2");
   endtask

   task automatic t_stop();    // R5
      do_wr(2'd3, 32'h0);
      for (int i = 0; i < 25; i++) begin
         chk(pwm_out == 1'b0, "R5", longint'(pwm_out), 0);
         fclk_en = 1'b1;
         @(negedge clk);
      end
   endtask

   task automatic t_inv();     // R4
      setup(TOP - 9, TOP - 6);
      do_wr(2'd3, 32'h2);
      chk(pwm_out == 1'b1, "R4", longint'(pwm_out), 1);
      fclk_en = 1'b1;
      do_wr(2'd3, 32'h3);
      run_trace(30, 2, 10, 4, 1, 1'b1, 0, -1, -1, "R4");
      do_wr(2'd3, 32'h0);
      chk(pwm_out == 1'b1, "R4", longint'(pwm_out), 1);
      do_wr(2'd3, 32'h0);
   endtask

   task automatic t_short();   // R2 R3: period of two steps
      setup(TOP - 1, TOP - 1);
      fclk_en = 1'b1;
      do_wr(2'd3, 32'h1);
      run_trace(14, 2, 2, 1, 1, 1'b0, 0, -1, -1, "R2");
   endtask

   task automatic t_keep();    // R3: start from written counter
      setup(TOP - 9, TOP - 6);
      do_wr(2'd2, 32'hFFFF_FFFA);
      fclk_en = 1'b1;
      do_wr(2'd3, 32'h5);
      run_trace(30, 6, 10, 4, 1, 1'b0, 0, -1, -1, "R3");
   endtask

   task automatic t_div();     // R7: divide by 4 with gapped enables
      setup(TOP - 4, TOP - 3);
      fclk_en = 1'b1;
      do_wr(2'd3, 32'h19);
      run_trace(110, 2, 5, 2, 4, 1'b0, 1, -1, -1, "R7");
   endtask

   task automatic t_err();     // R6: dropped writes mid-run
      setup(TOP - 9, TOP - 6);
      fclk_en = 1'b1;
      do_wr(2'd3, 32'h1);
      run_trace(45, 2, 10, 4, 1, 1'b0, 0, 7, 15, "R6");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_stop();
      t_inv();
      t_short();
      t_keep();
      t_div();
      t_err();
      t_stop();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule